// File: doc/BRIEF.md
# DRAM ECC Error Log Registers

This block sits inside a memory controller, next to the ECC checker, and keeps a record of DRAM ECC failures for software. Each cycle the checker may pulse a correctable or an uncorrectable event, together with the failing 33-bit physical address, the channel and the 8-bit syndrome. The block keeps sticky flags in a 16-bit status register and holds one captured error record. That record is a 128-byte-grain address split over a low and a high pointer register, plus the channel and the syndrome. Three more sticky sources share the status register: a refresh timeout, a locked access that targets non-DRAM memory, and a thermal sensor trip.

Software reads the registers through a flat read/write port, and clears flags by writing ones to them. The capture policy keeps the most important information. The first error after the log is empty is recorded. An uncorrectable error replaces a logged correctable one. An uncorrectable record is never replaced while its flag is still pending. A command register selects which sources drive the system-error output.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and `serr` is low.
- R2: A one-cycle event pulse sets a sticky status flag that stays set until cleared: correctable at bit 0, uncorrectable at bit 1, refresh timeout at bit 8, non-DRAM lock at bit 9, thermal at bit 11. Status sits at register offset 0 and all other status bits read zero.
- R3: Writing status clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag stays set. A cleared correctable or uncorrectable flag no longer protects the log, so the new event is captured.
- R5: The low pointer (offset 2) returns address bits 31:7 in bits 31:7, zero in bits 6:1 and the channel in bit 0.
- R6: The high pointer (offset 3) returns address bit 32 in bit 0 and zero elsewhere. The syndrome register (offset 4) returns the 8-bit syndrome in bits 7:0.
- R7: When neither the correctable nor the uncorrectable flag is set, an error event loads address, channel and syndrome.
- R8: A correctable event never changes a log while either the correctable or the uncorrectable flag is set.
- R9: An uncorrectable event that arrives while only a correctable error is logged replaces the record and sets bit 1. Bit 0 stays set.
- R10: A second uncorrectable event does not replace a record whose uncorrectable flag is still set.
- R11: The command register (offset 1) stores only bits 0, 1, 8, 9 and 11. All other bits read zero.
- R12: `serr` is high exactly while some bit is set in both status and command. It rises in the cycle after the event edge.
- R13: Writes to offsets 2, 3 and 4 have no effect.
- R14: Correctable and uncorrectable events in the same cycle set both flags and log the uncorrectable record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_evt | input | 1 | Correctable ECC error pulse |
| ue_evt | input | 1 | Uncorrectable ECC error pulse |
| err_addr | input | 33 | Physical address of the failing access |
| err_chan | input | 1 | Channel of the failing access |
| err_syn | input | 8 | ECC syndrome of the failing access |
| refresh_to_evt | input | 1 | Refresh timeout pulse |
| lock_nondram_evt | input | 1 | Locked access to non-DRAM memory pulse |
| thermal_evt | input | 1 | Thermal sensor trip pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the offset |
| serr | output | 1 | System-error request |

## Verification
A wrong capture decision is visible at the ports one cycle after the event edge: the pointer and syndrome reads return the old or the wrong record. A flag that is lost or stuck shows in the status read and, with the matching command bit enabled, on `serr` in that same cycle. The directed sequences build every ordering of correctable and uncorrectable events against pending and just-cleared flags, and read the full record after each step. An overwrite that should not happen, or one that is missed, therefore cannot hide behind a later event.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

  localparam int STAT_W    = 16;
  localparam int GRAIN_LSB = 7;

  localparam int BIT_CE  = 0;
  localparam int BIT_UE  = 1;
  localparam int BIT_RTO = 8;
  localparam int BIT_LCK = 9;
  localparam int BIT_THM = 11;

  localparam logic [STAT_W-1:0] SRC_MASK = 16'h0B03;

  typedef enum logic [2:0] {
    RA_STATUS = 3'd0,
    RA_CMD    = 3'd1,
    RA_PTR_LO = 3'd2,
    RA_PTR_HI = 3'd3,
    RA_SYN    = 3'd4
  } reg_off_e;

  // Places the event pulses at their status bit positions.
  function automatic logic [STAT_W-1:0] place_events(
    input logic ce, input logic ue, input logic rto,
    input logic lck, input logic thm);
    logic [STAT_W-1:0] v;
    v = '0;
    v[BIT_CE]  = ce;
    v[BIT_UE]  = ue;
    v[BIT_RTO] = rto;
    v[BIT_LCK] = lck;
    v[BIT_THM] = thm;
    return v;
  endfunction

  // Low pointer word: grain-aligned address with the channel in bit 0.
  function automatic logic [31:0] ptr_word(
    input logic [31:GRAIN_LSB] addr_hi_part, input logic chan);
    return {addr_hi_part, {(GRAIN_LSB-1){1'b0}}, chan};
  endfunction

endpackage

// File: rtl/ecc_log_flags.sv
module ecc_log_flags #(
  parameter int                W    = 16,
  parameter logic [W-1:0]      MASK = 16'h0B03
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] held
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_live
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n)          bit_q <= 1'b0;
        else if (evt_vec[i]) bit_q <= 1'b1;
        else if (clr_vec[i]) bit_q <= 1'b0;
      end
      assign flag_q[i] = bit_q;

      // R2: a set flag survives any cycle without a clearing write
      p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q && !clr_vec[i]) |=> bit_q);
      // R3: a clearing write without a new event drops the flag
      p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[i] && !evt_vec[i]) |=> !bit_q);
      // R4: an event always leaves the flag set, even under a clear
      p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vec[i] |=> bit_q);
    end else begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = evt_vec[i] | clr_vec[i];
      assign flag_q[i]   = 1'b0;
    end
  end

  // A flag counts as pending only if this cycle's write does not clear it.
  assign held = flag_q & ~clr_vec;

endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int ADDR_W    = 33,
  parameter int SYN_W     = 8,
  parameter int GRAIN_LSB = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce_evt,
  input  logic                      ue_evt,
  input  logic                      ce_held,
  input  logic                      ue_held,
  input  logic [ADDR_W-1:0]         err_addr,
  input  logic                      err_chan,
  input  logic [SYN_W-1:0]          err_syn,
  output logic [ADDR_W-1:GRAIN_LSB] addr_q,
  output logic                      chan_q,
  output logic [SYN_W-1:0]          syn_q,
  output logic                      load_ue,
  output logic                      load_ce
);

  logic unused_offs;
  assign unused_offs = ^err_addr[GRAIN_LSB-1:0];

  // An uncorrectable error may only replace a correctable record.
  assign load_ue = ue_evt & ~ue_held;
  // A correctable error is logged only into an empty log.
  assign load_ce = ce_evt & ~ue_evt & ~ce_held & ~ue_held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      chan_q <= 1'b0;
      syn_q  <= '0;
    end else if (load_ue || load_ce) begin
      addr_q <= err_addr[ADDR_W-1:GRAIN_LSB];
      chan_q <= err_chan;
      syn_q  <= err_syn;
    end
  end

  // R9: an accepted uncorrectable event lands in the record
  p_ue_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_ue |=> (syn_q == $past(err_syn)) && (chan_q == $past(err_chan)));
  // R8: a correctable event against a non-empty log changes nothing
  p_ce_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !ue_evt && (ce_held || ue_held)) |=>
      ($stable(syn_q) && $stable(addr_q) && $stable(chan_q)));
  // R10: a pending uncorrectable record is never replaced
  p_ue_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && ue_held) |=>
      ($stable(syn_q) && $stable(addr_q) && $stable(chan_q)));
  // R14: both events at once pick the uncorrectable path
  p_both_ue_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && ue_evt) |-> !load_ce);

endmodule

// File: rtl/ecc_log_serr.sv
module ecc_log_serr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] MASK = 16'h0B03
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_wr,
  input  logic [W-1:0] cmd_wdata,
  input  logic [W-1:0] status,
  output logic [W-1:0] cmd_q,
  output logic         serr
);

  always_ff @(posedge clk) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_wr) cmd_q <= cmd_wdata & MASK;
  end

  assign serr = |(status & cmd_q & MASK);

  // R12: no system error without a pending status flag
  p_serr_needs_status_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !serr);
  // R11: a command write keeps only the defined enable bits
  p_cmd_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (cmd_q == ($past(cmd_wdata) & MASK)));

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 33,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              err_chan,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              refresh_to_evt,
  input  logic              lock_nondram_evt,
  input  logic              thermal_evt,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              serr
);

  localparam int HI_W = ADDR_W - 32;

  logic [STAT_W-1:0] evt_vec, clr_vec, status_q, held, cmd_q;
  logic [ADDR_W-1:GRAIN_LSB] addr_q;
  logic chan_q, load_ue, load_ce;
  logic [SYN_W-1:0] syn_q;
  logic wr_status, wr_cmd;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata[31:STAT_W];

  assign wr_status = reg_wr && (reg_addr == RA_STATUS);
  assign wr_cmd    = reg_wr && (reg_addr == RA_CMD);
  assign clr_vec   = wr_status ? reg_wdata[STAT_W-1:0] : '0;
  assign evt_vec   = place_events(ce_evt, ue_evt, refresh_to_evt,
                                  lock_nondram_evt, thermal_evt);

  ecc_log_flags #(.W(STAT_W), .MASK(SRC_MASK)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_vec (evt_vec),
    .clr_vec (clr_vec),
    .flag_q  (status_q),
    .held    (held)
  );

  ecc_log_capture #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .GRAIN_LSB(GRAIN_LSB)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_evt   (ce_evt),
    .ue_evt   (ue_evt),
    .ce_held  (held[BIT_CE]),
    .ue_held  (held[BIT_UE]),
    .err_addr (err_addr),
    .err_chan (err_chan),
    .err_syn  (err_syn),
    .addr_q   (addr_q),
    .chan_q   (chan_q),
    .syn_q    (syn_q),
    .load_ue  (load_ue),
    .load_ce  (load_ce)
  );

  ecc_log_serr #(.W(STAT_W), .MASK(SRC_MASK)) u_serr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (wr_cmd),
    .cmd_wdata (reg_wdata[STAT_W-1:0]),
    .status    (status_q),
    .cmd_q     (cmd_q),
    .serr      (serr)
  );

  always_comb begin
    case (reg_addr)
      RA_STATUS: reg_rdata = {{(32-STAT_W){1'b0}}, status_q};
      RA_CMD:    reg_rdata = {{(32-STAT_W){1'b0}}, cmd_q};
      RA_PTR_LO: reg_rdata = ptr_word(addr_q[31:GRAIN_LSB], chan_q);
      RA_PTR_HI: reg_rdata = {{(32-HI_W){1'b0}}, addr_q[ADDR_W-1:32]};
      RA_SYN:    reg_rdata = {{(32-SYN_W){1'b0}}, syn_q};
      default:   reg_rdata = '0;
    endcase
  end

  // R7/R9: any capture leaves the corresponding flag set next cycle
  p_load_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ue || load_ce) |=> (status_q[BIT_CE] || status_q[BIT_UE]));
  // R1: registers start empty out of reset
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (status_q == '0) && (cmd_q == '0) && (syn_q == '0));

endmodule

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_evt = 0, ue_evt = 0, err_chan = 0;
  logic [32:0] err_addr = '0;
  logic [7:0]  err_syn = '0;
  logic refresh_to_evt = 0, lock_nondram_evt = 0, thermal_evt = 0;
  logic reg_wr = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic serr;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ecc_err_log u_dut (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .err_addr(err_addr), .err_chan(err_chan), .err_syn(err_syn),
    .refresh_to_evt(refresh_to_evt), .lock_nondram_evt(lock_nondram_evt),
    .thermal_evt(thermal_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serr(serr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lo_exp(input logic [32:0] a, input logic ch);
    return {a[31:0] & ~32'h7F} | {31'b0, ch};
  endfunction

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic err(input logic ce, input logic ue, input logic [32:0] a,
                     input logic ch, input logic [7:0] s);
    @(negedge clk);
    ce_evt = ce; ue_evt = ue; err_addr = a; err_chan = ch; err_syn = s;
    @(negedge clk);
    ce_evt = 0; ue_evt = 0;
  endtask

  task automatic check_log(input string req, input logic [32:0] a,
                           input logic ch, input logic [7:0] s);
    logic [31:0] d;
    rd(3'd2, d); check(req, d, lo_exp(a, ch));
    rd(3'd3, d); check(req, d, {31'b0, a[32]});
    rd(3'd4, d); check(req, d, {24'b0, s});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), d); check("R1 reg", d, 32'h0);
    end
    check("R1 serr", {31'b0, serr}, 32'h0);
  endtask

  task automatic t_ce_ue_order;
    logic [31:0] d;
    err(1, 0, 33'h1_2345_6789, 1, 8'h5A);
    rd(3'd0, d); check("R2 ce flag", d, 32'h1);
    check_log("R5 R6 R7 first ce", 33'h1_2345_6789, 1, 8'h5A);
    err(1, 0, 33'h0_0000_1000, 0, 8'h11);
    check_log("R8 second ce", 33'h1_2345_6789, 1, 8'h5A);
    err(0, 1, 33'h0_ABCD_EF80, 0, 8'hC3);
    rd(3'd0, d); check("R9 both flags", d, 32'h3);
    check_log("R9 ue replaces", 33'h0_ABCD_EF80, 0, 8'hC3);
    err(0, 1, 33'h1_FFFF_FFFF, 1, 8'hEE);
    check_log("R10 second ue", 33'h0_ABCD_EF80, 0, 8'hC3);
    err(1, 0, 33'h0_5555_5500, 1, 8'h22);
    check_log("R8 ce after ue", 33'h0_ABCD_EF80, 0, 8'hC3);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(3'd0, 32'h0);
    rd(3'd0, d); check("R3 zero write", d, 32'h3);
    wr(3'd0, 32'h2);
    rd(3'd0, d); check("R3 clear ue", d, 32'h1);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R3 clear all", d, 32'h0);
  endtask

  task automatic t_ro;
    for (int i = 2; i < 5; i++) wr(3'(i), 32'hFFFF_FFFF);
    check_log("R13 writes ignored", 33'h0_ABCD_EF80, 0, 8'hC3);
  endtask

  task automatic t_misc_and_serr;
    logic [31:0] d;
    @(negedge clk);
    refresh_to_evt = 1;
    @(negedge clk);
    refresh_to_evt = 0; lock_nondram_evt = 1;
    @(negedge clk);
    lock_nondram_evt = 0; thermal_evt = 1;
    @(negedge clk);
    thermal_evt = 0;
    rd(3'd0, d); check("R2 other sources", d, 32'h0B00);
    check("R12 serr off no cmd", {31'b0, serr}, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R11 cmd mask", d, 32'h0B03);
    check("R12 serr on", {31'b0, serr}, 32'h1);
    wr(3'd1, 32'h0000_0003);
    check("R12 serr unmatched", {31'b0, serr}, 32'h0);
    wr(3'd0, 32'h0B00);
    err(1, 0, 33'h0_0000_0080, 0, 8'h01);
    check("R12 serr on ce", {31'b0, serr}, 32'h1);
    wr(3'd0, 32'h1);
    check("R12 serr clear", {31'b0, serr}, 32'h0);
  endtask

  task automatic t_event_wins;
    logic [31:0] d;
    err(1, 0, 33'h0_1111_1100, 1, 8'h33);
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'd0; reg_wdata = 32'h1;
    ce_evt = 1; err_addr = 33'h1_2222_2280; err_chan = 0; err_syn = 8'h44;
    @(negedge clk);
    reg_wr = 0; ce_evt = 0;
    rd(3'd0, d); check("R4 flag kept", d, 32'h1);
    check_log("R4 new capture", 33'h1_2222_2280, 0, 8'h44);
    wr(3'd0, 32'h3);
    err(1, 1, 33'h0_7777_7700, 1, 8'h99);
    rd(3'd0, d); check("R14 both flags", d, 32'h3);
    check_log("R14 ue logged", 33'h0_7777_7700, 1, 8'h99);
    wr(3'd0, 32'h3);
    err(1, 0, 33'h1_0000_0F00, 1, 8'h07);
    check_log("R7 after clear", 33'h1_0000_0F00, 1, 8'h07);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ce_ue_order();
    t_w1c();
    t_ro();
    t_misc_and_serr();
    t_event_wins();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule